// File: doc/BRIEF.md
# Multi-Bank Signature Compressor

This block reduces the contents of an address window in up to sixteen memory banks (four by default) to one 16-bit signature. Each bank has its own multiple-input signature register. A single-cycle `start` pulse captures a bank mask and an inclusive address window. Each selected bank's register is reset, primed with a constant word, and then fed the window twice. The first pass runs with rising addresses and the second with falling addresses. All selected banks are read in parallel through a shared address and per-bank enables, and the bank data returns a fixed number of cycles later.

When both passes have drained, the per-bank signatures are folded one at a time into the bank-0 register, in ascending bank order. The value left in that register is published on `signature`, together with a one-cycle `done` pulse. A built-in self-test controller or a boot-time integrity checker would use it to compare memory contents against a known-good value without moving the data itself.

Top module: `misr_sig_compressor`

## Requirements
- R1: Every fold applies next = {reg[14:0], reg[15]^reg[4]^reg[2]^reg[1]} ^ word to a 16-bit signature register. Bit 15 is the most significant bit.
- R2: On an accepted start, all bank registers return to 0xFFFF. The next cycle folds the word 0xFFFF into the register of each selected bank only, so an unselected bank 0 still holds 0xFFFF when folding begins.
- R3: Once per cycle, `rd_addr` walks from `addr_lo` up to `addr_hi`, both inclusive. It then walks from `addr_hi` back down to `addr_lo`, which gives 2*(hi-lo+1) reads per run. A window of one word gives two reads of that word. The window must satisfy `addr_lo` <= `addr_hi`.
- R4: `rd_en` equals the captured bank mask (bit b = bank b) in every read cycle, and it is zero in all other cycles.
- R5: The word on bank b's slice of `rd_data` (bits b*16 to b*16+15) is folded into bank b's register RD_LAT cycles after its address was presented.
- R6: After all reads complete, each selected bank k, taken in ascending k, has its register folded into bank 0's register. For k=0 this folds bank 0's own current value.
- R7: With an all-zero mask, no reads are made, and the signature is 0xFFFF.
- R8: `done` is high for exactly one cycle per run. `signature` changes only in a cycle where `done` is high, and it then holds the result of R6.
- R9: A `start` pulse while `busy` is high is ignored, and the run in progress completes with its own result.
- R10: A `start` in the cycle where `done` is high is accepted and begins a new run.
- R11: `busy` is high from the cycle after an accepted start until the cycle in which `done` rises, and then it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (single-cycle pulse) |
| bank_sel | input | NB | Bank select mask, bit b selects bank b |
| addr_lo | input | AW | First address of the window (inclusive) |
| addr_hi | input | AW | Last address of the window (inclusive) |
| busy | output | 1 | A run is in progress |
| rd_en | output | NB | Per-bank read enable |
| rd_addr | output | AW | Read address shared by all banks |
| rd_data | input | NB*DW | Read data, bank b in slice b*DW +: DW |
| done | output | 1 | One-cycle completion pulse |
| signature | output | DW | Final signature, held between completions |

## Verification
The completion pulse of one run and the start of the next can fall in the same cycle. The bench provokes this by raising `start` in the very cycle where it observes `done`. It then judges that the finished run's signature is still correct, and that the new run's address sequence and signature match a fresh reference. A second overlap is a `start` issued in the middle of a read pass. The bench judges it by confirming that the address stream, the enables and the signature all follow the first run's arguments.

// File: rtl/misr_sig_pkg.sv
package misr_sig_pkg;
   localparam logic [15:0] PRIME_WORD = 16'hFFFF;

   typedef enum logic [2:0] {
      PH_IDLE, PH_PRIME, PH_RISE, PH_FALL, PH_DRAIN, PH_FOLD, PH_FIN
   } phase_t;

   function automatic logic [15:0] fold16(input logic [15:0] cur, input logic [15:0] word);
      fold16 = {cur[14:0], cur[15] ^ cur[4] ^ cur[2] ^ cur[1]} ^ word;
   endfunction
endpackage

// File: rtl/misr_lane.sv
module misr_lane
   import misr_sig_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   input  logic          ld,
   input  logic [DW-1:0] word,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst || clr) q <= PRIME_WORD;
      else if (ld)    q <= fold16(q, word);
   end
endmodule

// File: rtl/misr_walk_ctl.sv
module misr_walk_ctl
   import misr_sig_pkg::*;
#(
   parameter int NB     = 4,
   parameter int AW     = 8,
   parameter int RD_LAT = 2,
   localparam int CIW   = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [NB-1:0]  sel,
   input  logic [AW-1:0]  lo,
   input  logic [AW-1:0]  hi,
   output logic           busy,
   output logic           clr,
   output logic           prime_ld,
   output logic [NB-1:0]  sel_q,
   output logic           issue,
   output logic [AW-1:0]  addr,
   output logic           data_vld,
   output logic           fold_ld,
   output logic [CIW-1:0] fold_idx,
   output logic           fin
);
   phase_t            ph;
   logic [AW-1:0]     lo_q, hi_q, ptr;
   logic [RD_LAT-1:0] vpipe;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph <= PH_IDLE;
         sel_q <= '0;
         lo_q <= '0;
         hi_q <= '0;
         ptr <= '0;
         fold_idx <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: if (start) begin
               sel_q <= sel;
               lo_q <= lo;
               hi_q <= hi;
               ph <= PH_PRIME;
            end
            PH_PRIME: begin
               ptr <= lo_q;
               fold_idx <= '0;
               ph <= (sel_q == '0) ? PH_FOLD : PH_RISE;
            end
            PH_RISE: if (ptr == hi_q) ph <= PH_FALL;
                     else ptr <= ptr + 1'b1;
            PH_FALL: if (ptr == lo_q) ph <= PH_DRAIN;
                     else ptr <= ptr - 1'b1;
            PH_DRAIN: if (vpipe == '0) ph <= PH_FOLD;
            PH_FOLD: if (fold_idx == CIW'(NB - 1)) ph <= PH_FIN;
                     else fold_idx <= fold_idx + 1'b1;
            PH_FIN: ph <= PH_IDLE;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   generate
      if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk) begin
            if (rst) vpipe <= '0;
            else     vpipe <= issue;
         end
      end else begin : g_latn
         always_ff @(posedge clk) begin
            if (rst) vpipe <= '0;
            else     vpipe <= {vpipe[RD_LAT-2:0], issue};
         end
      end
   endgenerate

   assign busy     = (ph != PH_IDLE);
   assign clr      = (ph == PH_IDLE) && start;
   assign prime_ld = (ph == PH_PRIME);
   assign issue    = (ph == PH_RISE) || (ph == PH_FALL);
   assign addr     = ptr;
   assign data_vld = vpipe[RD_LAT-1];
   assign fold_ld  = (ph == PH_FOLD) && sel_q[fold_idx];
   assign fin      = (ph == PH_FIN);
endmodule

// File: rtl/misr_sig_compressor.sv
module misr_sig_compressor
   import misr_sig_pkg::*;
#(
   parameter int NB     = 4,
   parameter int AW     = 8,
   parameter int DW     = 16,
   parameter int RD_LAT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [NB-1:0]    bank_sel,
   input  logic [AW-1:0]    addr_lo,
   input  logic [AW-1:0]    addr_hi,
   output logic             busy,
   output logic [NB-1:0]    rd_en,
   output logic [AW-1:0]    rd_addr,
   input  logic [NB*DW-1:0] rd_data,
   output logic             done,
   output logic [DW-1:0]    signature
);
   localparam int CIW = (NB > 1) ? $clog2(NB) : 1;

   generate
      if (DW != 16)             begin : g_bad_dw  $error("DW must be 16");         end
      if (NB < 1 || NB > 16)    begin : g_bad_nb  $error("NB must be 1..16");      end
      if (RD_LAT < 1)           begin : g_bad_lat $error("RD_LAT must be >= 1");  end
      if (AW < 1)               begin : g_bad_aw  $error("AW must be >= 1");      end
   endgenerate

   logic           clr, prime_ld, issue, data_vld, fold_ld, fin;
   logic [NB-1:0]  sel_q;
   logic [CIW-1:0] fold_idx;
   logic [DW-1:0]  lane_q [NB];

   misr_walk_ctl #(.NB(NB), .AW(AW), .RD_LAT(RD_LAT)) u_ctl (
      .clk(clk), .rst(rst), .start(start), .sel(bank_sel), .lo(addr_lo), .hi(addr_hi),
      .busy(busy), .clr(clr), .prime_ld(prime_ld), .sel_q(sel_q), .issue(issue),
      .addr(rd_addr), .data_vld(data_vld), .fold_ld(fold_ld), .fold_idx(fold_idx), .fin(fin)
   );

   assign rd_en = issue ? sel_q : '0;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic          ld;
      logic [DW-1:0] word;
      if (b == 0) begin : g_base
         always_comb begin
            ld   = ((prime_ld || data_vld) && sel_q[0]) || fold_ld;
            word = prime_ld ? PRIME_WORD
                 : data_vld ? rd_data[0 +: DW]
                 : lane_q[fold_idx];
         end
      end else begin : g_side
         always_comb begin
            ld   = (prime_ld || data_vld) && sel_q[b];
            word = prime_ld ? PRIME_WORD : rd_data[b*DW +: DW];
         end
      end
      misr_lane #(.DW(DW)) u_lane (
         .clk(clk), .rst(rst), .clr(clr), .ld(ld), .word(word), .q(lane_q[b])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         done <= 1'b0;
         signature <= '0;
      end else begin
         done <= fin;
         if (fin) signature <= lane_q[0];
      end
   end
endmodule

// File: rtl/misr_sig_chk.sv
module misr_sig_chk #(
   parameter int NB = 4,
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic          busy,
   input logic [NB-1:0] rd_en,
   input logic          done,
   input logic [DW-1:0] signature
);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_sig_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(signature));
   assert_reads_busy_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_en != '0) |-> busy);
   assert_fall_done_R11: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);
   assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

bind misr_sig_compressor misr_sig_chk #(.NB(NB), .AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .start(start), .busy(busy), .rd_en(rd_en),
   .done(done), .signature(signature)
);

// File: tb/tb_misr_sig_compressor.sv
module tb_misr_sig_compressor;
   localparam int NB = 4, AW = 8, DW = 16, LAT = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0;
   logic [NB-1:0] bank_sel = '0, rd_en;
   logic [AW-1:0] addr_lo = '0, addr_hi = '0, rd_addr;
   logic [NB*DW-1:0] rd_data;
   logic busy, done;
   logic [DW-1:0] signature;

   always #4 clk = ~clk;

   misr_sig_compressor #(.NB(NB), .AW(AW), .DW(DW), .RD_LAT(LAT)) dut (
      .clk(clk), .rst(rst), .start(start), .bank_sel(bank_sel), .addr_lo(addr_lo),
      .addr_hi(addr_hi), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .done(done), .signature(signature)
   );

   logic [DW-1:0] mem [NB][DEPTH];
   logic [NB*DW-1:0] pipe [LAT];
   always @(posedge clk) begin
      for (int b = 0; b < NB; b++) pipe[0][b*DW +: DW] <= mem[b][rd_addr];
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
   end
   assign rd_data = pipe[LAT-1];

   int total = 0, bad = 0;
   int exp_q[$];
   logic [DW-1:0] exp_sig, prev_sig;
   logic [NB-1:0] exp_mask;
   logic pend = 1'b0, prev_done = 1'b0;
   string tag = "R1";

   function automatic logic [15:0] step(input logic [15:0] r, input logic [15:0] w);
      logic fb;
      fb = r[15] ^ r[4] ^ r[2] ^ r[1];
      return ((r << 1) | 16'(fb)) ^ w;
   endfunction

   function automatic logic [15:0] model(input logic [NB-1:0] m, input int lo, input int hi);
      logic [15:0] r [NB];
      logic [15:0] acc;
      for (int b = 0; b < NB; b++) begin
         r[b] = 16'hFFFF;
         if (m[b]) begin
            r[b] = step(r[b], 16'hFFFF);
            for (int a = lo; a <= hi; a++) r[b] = step(r[b], mem[b][a]);
            for (int a = hi; a >= lo; a--) r[b] = step(r[b], mem[b][a]);
         end
      end
      acc = r[0];
      for (int k = 0; k < NB; k++) if (m[k]) acc = step(acc, (k == 0) ? acc : r[k]);
      return acc;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) if (!rst) begin
      if (rd_en != '0) begin
         check("R4 rd_en mask", 64'(rd_en), 64'(exp_mask));
         if (exp_q.size() == 0) check("R3 extra read", 64'(rd_addr), 64'hFFFF_FFFF);
         else check("R3 address order", 64'(rd_addr), 64'(exp_q.pop_front()));
      end
      if (done) begin
         check("R8 done single cycle", 64'(prev_done), 64'd0);
         check("R8 done expected", 64'(pend), 64'd1);
         check("R3 all reads made", 64'(exp_q.size()), 64'd0);
         check({tag, " signature"}, 64'(signature), 64'(exp_sig));
         pend = 1'b0;
      end else begin
         check("R8 signature held", 64'(signature), 64'(prev_sig));
      end
      prev_sig = signature;
      prev_done = done;
   end

   // caller stands at a negedge
   task automatic launch(input logic [NB-1:0] m, input int lo, input int hi, input string t);
      #1;
      start = 1'b1; bank_sel = m; addr_lo = AW'(lo); addr_hi = AW'(hi);
      tag = t; exp_mask = m; exp_sig = model(m, lo, hi); pend = 1'b1;
      exp_q.delete();
      if (m != '0) begin
         for (int a = lo; a <= hi; a++) exp_q.push_back(a);
         for (int a = hi; a >= lo; a--) exp_q.push_back(a);
      end
      @(negedge clk);
      check("R11 busy after start", 64'(busy), 64'd1);
      #1 start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!done && n < 5000);
      if (!done) check("R8 done timeout", 64'd0, 64'd1);
   endtask

   task automatic run(input logic [NB-1:0] m, input int lo, input int hi, input string t);
      @(negedge clk);
      launch(m, lo, hi, t);
      wait_done();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++)
         for (int a = 0; a < DEPTH; a++) mem[b][a] = 16'($urandom);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset busy", 64'(busy), 64'd0);
      check("R8 reset done", 64'(done), 64'd0);
      check("R4 reset rd_en", 64'(rd_en), 64'd0);
      check("R8 reset signature", 64'(signature), 64'd0);
      prev_sig = signature;
      rst = 1'b0;

      run(4'b1111, 0, 0, "R3 single word R1 R6");
      run(4'b0001, 5, 9, "R1 R5 bank0 only");
      run(4'b0000, 3, 40, "R7 empty mask");
      check("R7 empty signature", 64'(signature), 64'hFFFF);
      run(4'b1110, 10, 12, "R2 bank0 unselected");
      run(4'b1010, 0, DEPTH - 1, "R3 full window");

      // R9: start during a run is ignored
      @(negedge clk);
      launch(4'b0110, 20, 30, "R9 ignored start");
      repeat (5) @(negedge clk);
      #1 start = 1'b1; bank_sel = 4'b1001; addr_lo = 8'd1; addr_hi = 8'd2;
      @(negedge clk);
      #1 start = 1'b0;
      wait_done();

      // R10: new start in the done cycle
      @(negedge clk);
      launch(4'b0011, 50, 53, "R10 first");
      wait_done();
      launch(4'b1101, 60, 62, "R10 back-to-back");
      check("R10 busy after done-cycle start", 64'(busy), 64'd1);
      wait_done();

      for (int i = 0; i < 20; i++) begin
         int lo, hi;
         lo = int'($urandom_range(0, DEPTH - 1));
         hi = int'($urandom_range(lo, (lo + 20 > DEPTH - 1) ? DEPTH - 1 : lo + 20));
         run(NB'($urandom), lo, hi, "R1 R6 random");
      end

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule